// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block sits beside a byte-wide memory and watches its access stream for a hidden unlock pattern made only of reads. When the five prefix addresses arrive in order and a sixth read selects a command, it raises a single-cycle request for either a save of the working array into nonvolatile cells or a reload from them. Writes, stray reads and repeated reads abandon a partial match. One final address is kept for factory test and does nothing.

Accesses are recognised on the falling edge of the active-low chip enable. That edge is brought into the system clock domain through a synchroniser chain. Address and write enable are taken at the detected edge. Output enable plays no part. While the transfer engine reports busy, the detector ignores the bus and stays idle.

Top module: `seqdet_top`

## Requirements
- R1: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F raise `store_req` for exactly one clock. It is visible on the third rising clock edge after `ce_n` first goes low for that sixth read.
- R2: The same five-read prefix followed by a read of 0x0F0E raises `recall_req` for one clock, with the same latency as R1.
- R3: After the prefix, a read of 0x139C raises no request and returns the detector to idle, so a lone later read of 0x0F0F raises nothing.
- R4: A step is taken only on a falling edge of `ce_n` with `we_n` high. An access with `we_n` low abandons any partial match and is never taken as a first step, even at address 0x0000.
- R5: A read whose address is not the next one expected abandons the partial match and raises no request. If that read is at 0x0000, it counts as the first step of a new attempt.
- R6: Two consecutive reads of the same address abandon the match, because no address repeats within the pattern.
- R7: The level of `oe_n` has no effect on detection or on the requests.
- R8: While `busy` is high, every access is ignored and the detector returns to idle. This holds when `busy` is high in the same cycle as the sixth read's detected edge.
- R9: A synchronous active-high `rst` clears the detector to idle with both requests low.
- R10: `store_req` and `recall_req` are never high together, and neither is high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Transfer in progress; accesses ignored while high |
| addr | input | 13 | Memory address bus |
| ce_n | input | 1 | Chip enable, active low; its falling edge marks an access |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; not used for detection |
| store_req | output | 1 | One-clock request to save the array |
| recall_req | output | 1 | One-clock request to reload the array |

## Verification
Two functions can act in the same cycle: the sixth read's detected chip-enable edge, which would issue a command, and a high `busy`, which forces idle. The bench raises `busy` for exactly the cycle in which that edge is seen. The scoreboard then expects no request, and expects a clean sequence straight afterwards to work. A second collision is an abort and a restart in one edge: a stray read of 0x0000 must end the old attempt and begin a new one. This is judged by completing the sequence from that read.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   localparam int PATTERN_W   = 13;
   localparam int PREFIX_LEN  = 5;

   localparam logic [PATTERN_W-1:0] CMD_SAVE_ADDR   = 13'h0F0F;
   localparam logic [PATTERN_W-1:0] CMD_RELOAD_ADDR = 13'h0F0E;

   // Prefix addresses in the order they must be read.
   function automatic logic [PATTERN_W-1:0] prefix_addr(input int idx);
      case (idx)
         0:       return 13'h0000;
         1:       return 13'h1555;
         2:       return 13'h0AAA;
         3:       return 13'h1FFF;
         default: return 13'h10F0;
      endcase
   endfunction

endpackage

// File: rtl/seqdet_ce_edge.sv
module seqdet_ce_edge #(
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              ce_fall,
   output logic              wr_n_s,
   output logic [ADDR_W-1:0] addr_s
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("seqdet_ce_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sync_q[0] <= 1'b1;
            else     sync_q[0] <= ce_n;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b1;
            else     sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_q <= 1'b1;
         wr_n_s <= 1'b1;
         addr_s <= '0;
      end else begin
         last_q <= sync_q[SYNC_STAGES-1];
         wr_n_s <= we_n;
         addr_s <= addr;
      end
   end

   assign ce_fall = last_q & ~sync_q[SYNC_STAGES-1];

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ce_fall |=> !ce_fall);  // R4

endmodule

// File: rtl/seqdet_match.sv
module seqdet_match
   import seqdet_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0]     addr_s,
   output logic [PREFIX_LEN-1:0] hit_prefix,
   output logic                  hit_save,
   output logic                  hit_reload
);

   if (ADDR_W < PATTERN_W) begin : g_bad_width
      $error("seqdet_match: ADDR_W narrower than the pattern");
   end

   localparam int HI_W = ADDR_W - PATTERN_W;

   logic upper_zero;
   logic [PATTERN_W-1:0] low_addr;

   assign low_addr = addr_s[PATTERN_W-1:0];

   if (HI_W > 0) begin : g_upper
      assign upper_zero = (addr_s[ADDR_W-1:PATTERN_W] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   for (genvar k = 0; k < PREFIX_LEN; k++) begin : g_cmp
      assign hit_prefix[k] = upper_zero && (low_addr == prefix_addr(k));
   end

   assign hit_save   = upper_zero && (low_addr == CMD_SAVE_ADDR);
   assign hit_reload = upper_zero && (low_addr == CMD_RELOAD_ADDR);

endmodule

// File: rtl/seqdet_fsm.sv
module seqdet_fsm
   import seqdet_pkg::*;
#(
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  busy,
   input  logic                  ce_fall,
   input  logic                  wr_n_s,
   input  logic [PREFIX_LEN-1:0] hit_prefix,
   input  logic                  hit_save,
   input  logic                  hit_reload,
   output logic                  store_req,
   output logic                  recall_req
);

   localparam int STEP_W = $clog2(PREFIX_LEN + 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);
   localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

   logic [STEP_W-1:0] step_q, step_d;
   logic              save_d, reload_d;
   logic              expect_hit;
   logic [STEP_W-1:0] abort_step;

   // Abort target: idle, or step one if the stray read opens a new attempt.
   if (RESTART_ON_FIRST) begin : g_restart
      assign abort_step = hit_prefix[0] ? ONE_STEP : '0;
   end else begin : g_drop
      assign abort_step = '0;
   end

   always_comb begin
      expect_hit = 1'b0;
      for (int k = 0; k < PREFIX_LEN; k++) begin
         if (step_q == STEP_W'(k)) expect_hit = hit_prefix[k];
      end
   end

   always_comb begin
      step_d   = step_q;
      save_d   = 1'b0;
      reload_d = 1'b0;
      if (busy) begin
         step_d = '0;
      end else if (ce_fall) begin
         if (!wr_n_s) begin
            step_d = '0;
         end else if (step_q < LAST_STEP) begin
            step_d = expect_hit ? step_q + ONE_STEP : abort_step;
         end else if (hit_save) begin
            step_d = '0;
            save_d = 1'b1;
         end else if (hit_reload) begin
            step_d   = '0;
            reload_d = 1'b1;
         end else begin
            step_d = abort_step;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q     <= '0;
         store_req  <= 1'b0;
         recall_req <= 1'b0;
      end else begin
         step_q     <= step_d;
         store_req  <= save_d;
         recall_req <= reload_d;
      end
   end

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(store_req && recall_req));  // R10
   AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      store_req |=> !store_req);  // R10
   AST_RECALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      recall_req |=> !recall_req);  // R10
   AST_STORE_AFTER_PREFIX: assert property (@(posedge clk) disable iff (rst)
      store_req |-> $past(step_q) == LAST_STEP);  // R1
   AST_RECALL_AFTER_PREFIX: assert property (@(posedge clk) disable iff (rst)
      recall_req |-> $past(step_q) == LAST_STEP);  // R2
   AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst)
      busy |=> (step_q == '0) && !store_req && !recall_req);  // R8
   AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (rst)
      (ce_fall && !wr_n_s) |=> (step_q == '0) && !store_req && !recall_req);  // R4
   AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
      (!ce_fall && !busy) |=> step_q == $past(step_q));  // R4

endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
   import seqdet_pkg::*;
#(
   parameter int ADDR_W           = 13,
   parameter int SYNC_STAGES      = 2,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   output logic              store_req,
   output logic              recall_req
);

   logic                  ce_fall;
   logic                  wr_n_s;
   logic [ADDR_W-1:0]     addr_s;
   logic [PREFIX_LEN-1:0] hit_prefix;
   logic                  hit_save;
   logic                  hit_reload;
   logic                  oe_unused;

   // Output enable is accepted for pin compatibility only.
   assign oe_unused = oe_n;

   seqdet_ce_edge #(
      .ADDR_W      (ADDR_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk     (clk),
      .rst     (rst),
      .ce_n    (ce_n),
      .we_n    (we_n),
      .addr    (addr),
      .ce_fall (ce_fall),
      .wr_n_s  (wr_n_s),
      .addr_s  (addr_s)
   );

   seqdet_match #(
      .ADDR_W (ADDR_W)
   ) u_match (
      .addr_s     (addr_s),
      .hit_prefix (hit_prefix),
      .hit_save   (hit_save),
      .hit_reload (hit_reload)
   );

   seqdet_fsm #(
      .RESTART_ON_FIRST (RESTART_ON_FIRST)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .busy       (busy),
      .ce_fall    (ce_fall),
      .wr_n_s     (wr_n_s),
      .hit_prefix (hit_prefix),
      .hit_save   (hit_save),
      .hit_reload (hit_reload),
      .store_req  (store_req),
      .recall_req (recall_req)
   );

endmodule

// File: tb/tb_seqdet_top.sv
module tb_seqdet_top;

   typedef struct {
      int    kind;   // 1 save, 2 reload
      int    cyc;
      string req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        busy = 1'b0;
   logic [12:0] addr = '0;
   logic        ce_n = 1'b1;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        store_req, recall_req;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   seqdet_top dut (
      .clk        (clk),
      .rst        (rst),
      .busy       (busy),
      .addr       (addr),
      .ce_n       (ce_n),
      .we_n       (we_n),
      .oe_n       (oe_n),
      .store_req  (store_req),
      .recall_req (recall_req)
   );

   // Monitor: every request pops the scoreboard and is compared.
   always @(negedge clk) begin
      if (!rst && (store_req || recall_req)) begin
         int got;
         got = store_req ? 1 : 2;
         checks++;
         if (store_req && recall_req) begin
            errors++;
            $display("FAIL R10: both requests high, got 11 expected one-hot");
         end else if (sb.size() == 0) begin
            errors++;
            $display("FAIL R10: unexpected request kind %0d at cycle %0d, expected none", got, cyc);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.kind != got || e.cyc != cyc) begin
               errors++;
               $display("FAIL %s: request kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                        e.req, got, cyc, e.kind, e.cyc);
            end
         end
      end
   end

   task automatic access(input logic [12:0] a, input bit wr, input int kind, input string req);
      @(negedge clk);
      addr = a;
      we_n = wr ? 1'b0 : 1'b1;
      ce_n = 1'b0;
      if (kind != 0) sb.push_back('{kind, cyc + 3, req});
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      we_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic prefix();
      access(13'h0000, 0, 0, "");
      access(13'h1555, 0, 0, "");
      access(13'h0AAA, 0, 0, "");
      access(13'h1FFF, 0, 0, "");
      access(13'h10F0, 0, 0, "");
   endtask

   task automatic settle(input string req);
      repeat (4) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d expected request(s) missing, expected 0", req, sb.size());
         sb.delete();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (store_req !== 1'b0 || recall_req !== 1'b0) begin
         errors++;
         $display("FAIL R9: requests %b%b during reset, expected 00", store_req, recall_req);
      end
      rst = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (store_req !== 1'b0 || recall_req !== 1'b0) begin
         errors++;
         $display("FAIL R9: requests %b%b after reset, expected 00", store_req, recall_req);
      end

      // R1 save sequence
      prefix(); access(13'h0F0F, 0, 1, "R1"); settle("R1");
      // R2 reload sequence
      prefix(); access(13'h0F0E, 0, 2, "R2"); settle("R2");
      // R3 reserved final, then a lone save address, then a clean save
      prefix(); access(13'h139C, 0, 0, "R3"); settle("R3");
      access(13'h0F0F, 0, 0, "R3"); settle("R3");
      prefix(); access(13'h0F0F, 0, 1, "R3"); settle("R3");
      // R4 write in the middle aborts
      access(13'h0000, 0, 0, ""); access(13'h1555, 0, 0, "");
      access(13'h0AAA, 1, 0, "");
      access(13'h0AAA, 0, 0, ""); access(13'h1FFF, 0, 0, "");
      access(13'h10F0, 0, 0, ""); access(13'h0F0F, 0, 0, "R4"); settle("R4");
      // R4 a write at 0x0000 is not a first step
      access(13'h0000, 1, 0, "");
      access(13'h1555, 0, 0, ""); access(13'h0AAA, 0, 0, "");
      access(13'h1FFF, 0, 0, ""); access(13'h10F0, 0, 0, "");
      access(13'h0F0F, 0, 0, "R4"); settle("R4");
      // R5 mismatch aborts
      access(13'h0000, 0, 0, ""); access(13'h1555, 0, 0, "");
      access(13'h0123, 0, 0, "");
      access(13'h0AAA, 0, 0, ""); access(13'h1FFF, 0, 0, "");
      access(13'h10F0, 0, 0, ""); access(13'h0F0F, 0, 0, "R5"); settle("R5");
      // R5 stray 0x0000 restarts the attempt
      access(13'h0000, 0, 0, ""); access(13'h1555, 0, 0, ""); access(13'h0AAA, 0, 0, "");
      prefix(); access(13'h0F0E, 0, 2, "R5"); settle("R5");
      // R6 repeated address aborts
      access(13'h0000, 0, 0, ""); access(13'h1555, 0, 0, ""); access(13'h1555, 0, 0, "");
      access(13'h0AAA, 0, 0, ""); access(13'h1FFF, 0, 0, "");
      access(13'h10F0, 0, 0, ""); access(13'h0F0F, 0, 0, "R6"); settle("R6");
      // R7 output enable low and toggling
      oe_n = 1'b0; access(13'h0000, 0, 0, ""); oe_n = 1'b1; access(13'h1555, 0, 0, "");
      oe_n = 1'b0; access(13'h0AAA, 0, 0, ""); access(13'h1FFF, 0, 0, "");
      oe_n = 1'b1; access(13'h10F0, 0, 0, ""); oe_n = 1'b0;
      access(13'h0F0E, 0, 2, "R7"); oe_n = 1'b1; settle("R7");
      // R8 busy in the middle forces idle
      access(13'h0000, 0, 0, ""); access(13'h1555, 0, 0, "");
      busy = 1'b1; access(13'h0AAA, 0, 0, ""); busy = 1'b0;
      access(13'h1FFF, 0, 0, ""); access(13'h10F0, 0, 0, "");
      access(13'h0F0F, 0, 0, "R8"); settle("R8");
      // R8 busy in the same cycle as the final detected edge
      prefix();
      @(negedge clk); addr = 13'h0F0F; ce_n = 1'b0;
      repeat (2) @(negedge clk); busy = 1'b1;
      @(negedge clk); busy = 1'b0;
      repeat (2) @(negedge clk); ce_n = 1'b1;
      repeat (3) @(negedge clk);
      settle("R8");
      prefix(); access(13'h0F0F, 0, 1, "R8"); settle("R8");
      // R10 back-to-back commands stay single and separate
      prefix(); access(13'h0F0F, 0, 1, "R10");
      prefix(); access(13'h0F0E, 0, 2, "R10"); settle("R10");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule